// File: doc/BRIEF.md
# Vector Predicate Compare and Mask Merge Unit

This unit turns a compressed conditional-branch encoding into an element-wise compare whenever the operands are vectors. It does not redirect the program counter. It compares element i of the first source vector with element i of the second and places each outcome in bit i of a predicate word. It then reports that word together with the number of the predicate register that should receive it. Integer compares are signed. Float compares cover equality and ordering on IEEE-style sign/exponent/mantissa elements. The register file stays outside the block: the caller reads the source vectors named by the instruction fields and presents them next to the instruction.

The second half of the unit is a mask merge. It is used by a later vector operation that writes under a predicate. For each element index it keeps the freshly computed value where the mask bit is set and the index lies below the vector length. Every other element keeps its previous contents. Nothing is forced to zero, so a predicate word can later be inverted or combined to drive the complementary update.

Top module: `vpred_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: A compare is accepted when `cmp_valid` is high, bits 1:0 of `cmp_instr` equal 01, and bits 15:14 equal 11. One cycle later `pred_we` is high and `pred_reg` equals 8 plus bits 12:10. Without a compare, `pred_we` is low and `pred_reg` and `pred_bits` hold their previous values.
- R3: When bit 6 is 0 (integer bank), the operator comes from bit 13 and bit 5. Bit 13 = 0 with bit 5 = 0 selects equal. Bit 13 = 0 with bit 5 = 1 selects signed less-than. Bit 13 = 1 with bit 5 = 0 selects not-equal. Bit 13 = 1 with bit 5 = 1 selects signed greater-or-equal. Bit i of `pred_bits` is the result for `src_a[i*EW +: EW]` against `src_b[i*EW +: EW]`.
- R4: When bit 6 is 1 (float bank), equal and less-than follow ordering on the float value. A NaN operand, meaning an all-ones exponent with a nonzero mantissa, makes both results 0. Positive and negative zero compare equal.
- R5: A float-bank compare that selects not-equal or greater-or-equal raises `cmp_illegal` for one cycle, one cycle later, and produces no `pred_we`.
- R6: Bits of `pred_bits` at indices equal to or above `vec_len` are 0 after a compare. Any `vec_len` above NELEM covers every element.
- R7: An instruction that is not a compare encoding (bits 1:0 not 01, or bits 15:14 not 11) produces neither `pred_we` nor `cmp_illegal`.
- R8: One cycle after `mrg_valid`, `mrg_done` pulses. Element i of `mrg_out` equals element i of `mrg_new` when `mrg_mask[i]` is 1 and i < `vec_len`, and otherwise equals element i of `mrg_old`. Without `mrg_valid`, `mrg_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_len | input | VLW | Active element count for both compare and merge |
| cmp_valid | input | 1 | Instruction and source vectors present |
| cmp_instr | input | 16 | Compressed compare encoding |
| src_a | input | NELEM*EW | First source vector |
| src_b | input | NELEM*EW | Second source vector |
| pred_we | output | 1 | Predicate word ready to write |
| pred_reg | output | 5 | Destination predicate register number |
| pred_bits | output | NELEM | One compare result per element |
| cmp_illegal | output | 1 | Unsupported float operator seen |
| mrg_valid | input | 1 | Merge request |
| mrg_mask | input | NELEM | Per-element write enable |
| mrg_old | input | NELEM*EW | Previous destination vector |
| mrg_new | input | NELEM*EW | Newly computed vector |
| mrg_done | output | 1 | Merge result ready |
| mrg_out | output | NELEM*EW | Merged vector |

## Verification
Both paths deliver their results exactly one clock edge after the inputs are sampled. This applies to `pred_we`, `pred_reg`, `pred_bits` and `cmp_illegal` on the compare side, and to `mrg_done` and `mrg_out` on the merge side. The bench drives a new stimulus at each falling edge and computes the outcome from the requirements. At the next falling edge, after the single register stage has updated, it compares every output with that expectation. Held values are tracked as well: when no compare or merge was issued, the expectation keeps its previous contents.

// File: rtl/vpred_pkg.sv
package vpred_pkg;

  typedef enum logic [1:0] {
    OP_EQ = 2'd0,
    OP_LT = 2'd1,
    OP_NE = 2'd2,
    OP_GE = 2'd3
  } cmp_op_e;

  typedef struct packed {
    logic       is_cmp;
    logic       is_flt;
    cmp_op_e    op;
    logic [2:0] pdst;
  } cmp_dec_t;

  localparam logic [1:0] QUAD_CMP = 2'b01;
  localparam logic [1:0] F3_HIGH  = 2'b11;

endpackage

// File: rtl/vpred_decode.sv
module vpred_decode
  import vpred_pkg::*;
(
  input  logic [15:0] instr,
  output cmp_dec_t    dec
);
  logic sel_hi, ext;

  always_comb begin
    sel_hi     = instr[13];
    ext        = instr[5];
    dec.is_cmp = (instr[1:0] == QUAD_CMP) && (instr[15:14] == F3_HIGH);
    dec.is_flt = instr[6];
    dec.pdst   = instr[12:10];
    unique case ({sel_hi, ext})
      2'b00:   dec.op = OP_EQ;
      2'b01:   dec.op = OP_LT;
      2'b10:   dec.op = OP_NE;
      default: dec.op = OP_GE;
    endcase
  end
endmodule

// File: rtl/vpred_lane.sv
module vpred_lane
  import vpred_pkg::*;
#(
  parameter int EW   = 16,
  parameter int EXPW = 5
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic          is_flt,
  input  cmp_op_e       op,
  output logic          hit
);
  localparam int MANW = EW - EXPW - 1;

  logic          i_eq, i_lt;
  logic          nan_a, nan_b, both_zero, ordered;
  logic          f_eq, f_lt;
  logic [EW-2:0] mag_a, mag_b;
  logic          sa, sb;

  always_comb begin
    i_eq = (a == b);
    i_lt = ($signed(a) < $signed(b));

    sa    = a[EW-1];
    sb    = b[EW-1];
    mag_a = a[EW-2:0];
    mag_b = b[EW-2:0];
    nan_a = (&a[EW-2 -: EXPW]) && (|a[MANW-1:0]);
    nan_b = (&b[EW-2 -: EXPW]) && (|b[MANW-1:0]);
    ordered   = !nan_a && !nan_b;
    both_zero = (mag_a == '0) && (mag_b == '0);

    f_eq = ordered && (both_zero || (a == b));
    if (!ordered || both_zero)
      f_lt = 1'b0;
    else if (sa != sb)
      f_lt = sa;
    else if (!sa)
      f_lt = mag_a < mag_b;
    else
      f_lt = mag_a > mag_b;

    unique case (op)
      OP_EQ:   hit = is_flt ? f_eq : i_eq;
      OP_LT:   hit = is_flt ? f_lt : i_lt;
      OP_NE:   hit = !i_eq;
      default: hit = !i_lt;
    endcase
  end
endmodule

// File: rtl/vpred_merge.sv
module vpred_merge #(
  parameter int NELEM = 8,
  parameter int EW    = 16,
  parameter int VLW   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic [VLW-1:0]      vl,
  input  logic [NELEM-1:0]    mask,
  input  logic [NELEM*EW-1:0] old_v,
  input  logic [NELEM*EW-1:0] new_v,
  output logic                done,
  output logic [NELEM*EW-1:0] out_v
);
  logic [NELEM*EW-1:0] pick;

  for (genvar g = 0; g < NELEM; g++) begin : g_el
    logic live;
    assign live = mask[g] && (int'(vl) > g);
    assign pick[g*EW +: EW] = live ? new_v[g*EW +: EW] : old_v[g*EW +: EW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      out_v <= '0;
    end else begin
      done <= valid;
      if (valid) out_v <= pick;
    end
  end
endmodule

// File: rtl/vpred_unit.sv
module vpred_unit
  import vpred_pkg::*;
#(
  parameter int NELEM = 8,
  parameter int EW    = 16,
  parameter int EXPW  = 5,
  parameter int VLW   = $clog2(NELEM + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [VLW-1:0]      vec_len,
  input  logic                cmp_valid,
  input  logic [15:0]         cmp_instr,
  input  logic [NELEM*EW-1:0] src_a,
  input  logic [NELEM*EW-1:0] src_b,
  output logic                pred_we,
  output logic [4:0]          pred_reg,
  output logic [NELEM-1:0]    pred_bits,
  output logic                cmp_illegal,
  input  logic                mrg_valid,
  input  logic [NELEM-1:0]    mrg_mask,
  input  logic [NELEM*EW-1:0] mrg_old,
  input  logic [NELEM*EW-1:0] mrg_new,
  output logic                mrg_done,
  output logic [NELEM*EW-1:0] mrg_out
);
  localparam logic [1:0] CREG_BASE = 2'b01;

  cmp_dec_t         dec;
  logic [NELEM-1:0] raw_hits;
  logic [NELEM-1:0] len_mask;
  logic             bad_flt, do_write, do_flag;

  vpred_decode u_dec (
    .instr (cmp_instr),
    .dec   (dec)
  );

  for (genvar g = 0; g < NELEM; g++) begin : g_lane
    vpred_lane #(.EW(EW), .EXPW(EXPW)) u_lane (
      .a      (src_a[g*EW +: EW]),
      .b      (src_b[g*EW +: EW]),
      .is_flt (dec.is_flt),
      .op     (dec.op),
      .hit    (raw_hits[g])
    );
    assign len_mask[g] = int'(vec_len) > g;
  end

  always_comb begin
    bad_flt  = dec.is_flt && ((dec.op == OP_NE) || (dec.op == OP_GE));
    do_flag  = cmp_valid && dec.is_cmp && bad_flt;
    do_write = cmp_valid && dec.is_cmp && !bad_flt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_we     <= 1'b0;
      pred_reg    <= '0;
      pred_bits   <= '0;
      cmp_illegal <= 1'b0;
    end else begin
      pred_we     <= do_write;
      cmp_illegal <= do_flag;
      if (do_write) begin
        pred_reg  <= {CREG_BASE, dec.pdst};
        pred_bits <= raw_hits & len_mask;
      end
    end
  end

  vpred_merge #(.NELEM(NELEM), .EW(EW), .VLW(VLW)) u_mrg (
    .clk   (clk),
    .rst   (rst),
    .valid (mrg_valid),
    .vl    (vec_len),
    .mask  (mrg_mask),
    .old_v (mrg_old),
    .new_v (mrg_new),
    .done  (mrg_done),
    .out_v (mrg_out)
  );
endmodule

// File: rtl/vpred_unit_chk.sv
module vpred_unit_chk #(
  parameter int NELEM = 8,
  parameter int EW    = 16,
  parameter int VLW   = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [VLW-1:0]      vec_len,
  input logic                cmp_valid,
  input logic                pred_we,
  input logic [4:0]          pred_reg,
  input logic [NELEM-1:0]    pred_bits,
  input logic                cmp_illegal,
  input logic                mrg_valid,
  input logic [NELEM-1:0]    mrg_mask,
  input logic [NELEM*EW-1:0] mrg_old,
  input logic                mrg_done,
  input logic [NELEM*EW-1:0] mrg_out
);
  logic [VLW-1:0]      prev_vl;
  logic [NELEM-1:0]    prev_mask;
  logic [NELEM*EW-1:0] prev_old;
  logic                tail_ok, keep_ok;

  always_ff @(posedge clk) begin
    prev_vl   <= vec_len;
    prev_mask <= mrg_mask;
    prev_old  <= mrg_old;
  end

  always_comb begin
    tail_ok = 1'b1;
    keep_ok = 1'b1;
    for (int i = 0; i < NELEM; i++) begin
      if (int'(prev_vl) <= i && pred_bits[i]) tail_ok = 1'b0;
      if ((!prev_mask[i] || int'(prev_vl) <= i) &&
          (mrg_out[i*EW +: EW] != prev_old[i*EW +: EW])) keep_ok = 1'b0;
    end
  end

  assert_we_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    pred_we |-> $past(cmp_valid));
  assert_reg_range_R2: assert property (@(posedge clk) disable iff (rst)
    pred_we |-> (pred_reg[4:3] == 2'b01));
  assert_illegal_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    cmp_illegal |-> !pred_we);
  assert_tail_clear_R6: assert property (@(posedge clk) disable iff (rst)
    pred_we |-> tail_ok);
  assert_masked_keep_R8: assert property (@(posedge clk) disable iff (rst)
    mrg_done |-> keep_ok);
  assert_done_follows_req_R8: assert property (@(posedge clk) disable iff (rst)
    mrg_done |-> $past(mrg_valid));
endmodule

bind vpred_unit vpred_unit_chk #(.NELEM(NELEM), .EW(EW), .VLW(VLW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .vec_len     (vec_len),
  .cmp_valid   (cmp_valid),
  .pred_we     (pred_we),
  .pred_reg    (pred_reg),
  .pred_bits   (pred_bits),
  .cmp_illegal (cmp_illegal),
  .mrg_valid   (mrg_valid),
  .mrg_mask    (mrg_mask),
  .mrg_old     (mrg_old),
  .mrg_done    (mrg_done),
  .mrg_out     (mrg_out)
);

// File: tb/sim_vpred_unit.sv
`timescale 1ns/1ps
module sim_vpred_unit;
  localparam int NE  = 8;
  localparam int EW  = 16;
  localparam int VLW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [VLW-1:0]   vec_len = '0;
  logic             cmp_valid = 1'b0;
  logic [15:0]      cmp_instr = '0;
  logic [NE*EW-1:0] src_a = '0, src_b = '0;
  logic             pred_we, cmp_illegal, mrg_done;
  logic [4:0]       pred_reg;
  logic [NE-1:0]    pred_bits;
  logic             mrg_valid = 1'b0;
  logic [NE-1:0]    mrg_mask = '0;
  logic [NE*EW-1:0] mrg_old = '0, mrg_new = '0, mrg_out;

  vpred_unit u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  logic             e_we = 0, e_ill = 0, e_mdone = 0;
  logic [4:0]       e_reg = 0;
  logic [NE-1:0]    e_bits = 0;
  logic [NE*EW-1:0] e_mout = 0;
  string            e_tag = "R3";

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_nan(logic [15:0] x);
    return (x[14:10] == 5'h1f) && (x[9:0] != 0);
  endfunction

  function automatic int fkey(logic [15:0] x);
    int m = int'(x[14:0]);
    return x[15] ? -m : m;
  endfunction

  // reference: apply stimulus, compute expectation for next cycle
  task automatic drive(bit cv, logic [15:0] ins, logic [VLW-1:0] vl,
                       logic [NE*EW-1:0] a, logic [NE*EW-1:0] b,
                       bit mv, logic [NE-1:0] mk, logic [NE*EW-1:0] od,
                       logic [NE*EW-1:0] nw);
    bit iscmp, fl, ill;
    int kind;
    cmp_valid = cv; cmp_instr = ins; vec_len = vl; src_a = a; src_b = b;
    mrg_valid = mv; mrg_mask = mk; mrg_old = od; mrg_new = nw;
    iscmp = (ins[1:0] == 2'b01) && (ins[15:14] == 2'b11);
    fl    = ins[6];
    kind  = ins[13] ? (ins[5] ? 3 : 2) : (ins[5] ? 1 : 0);
    ill   = cv && iscmp && fl && kind >= 2;
    e_ill = ill;
    e_we  = cv && iscmp && !ill;
    e_tag = fl ? "R4" : "R3";
    if (e_we) begin
      e_reg = 5'(8 + int'(ins[12:10]));
      for (int i = 0; i < NE; i++) begin
        logic [15:0] x = a[i*EW +: EW];
        logic [15:0] y = b[i*EW +: EW];
        bit r;
        if (!fl) begin
          case (kind)
            0: r = (x == y);
            1: r = $signed(x) < $signed(y);
            2: r = (x != y);
            default: r = $signed(x) >= $signed(y);
          endcase
        end else if (is_nan(x) || is_nan(y)) r = 0;
        else if (kind == 0) r = (fkey(x) == fkey(y));
        else r = (fkey(x) < fkey(y));
        e_bits[i] = (i < int'(vl)) ? r : 1'b0;
      end
    end
    e_mdone = mv;
    if (mv)
      for (int i = 0; i < NE; i++)
        e_mout[i*EW +: EW] = (mk[i] && i < int'(vl)) ? nw[i*EW +: EW] : od[i*EW +: EW];
  endtask

  task automatic step(bit cv, logic [15:0] ins, logic [VLW-1:0] vl,
                      logic [NE*EW-1:0] a, logic [NE*EW-1:0] b,
                      bit mv, logic [NE-1:0] mk, logic [NE*EW-1:0] od,
                      logic [NE*EW-1:0] nw);
    drive(cv, ins, vl, a, b, mv, mk, od, nw);
    @(negedge clk);
    chk("R2/R7", "pred_we", 128'(pred_we), 128'(e_we));
    chk("R5", "cmp_illegal", 128'(cmp_illegal), 128'(e_ill));
    chk("R2", "pred_reg", 128'(pred_reg), 128'(e_reg));
    chk({e_tag, "/R6"}, "pred_bits", 128'(pred_bits), 128'(e_bits));
    chk("R8", "mrg_done", 128'(mrg_done), 128'(e_mdone));
    chk("R8", "mrg_out", 128'(mrg_out), 128'(e_mout));
  endtask

  function automatic logic [15:0] mk_cmp(bit hi, bit ext, bit fl, int pd, bit legal_q);
    return {2'b11, hi, 3'(pd), 3'd1, fl, ext, 3'd2, legal_q ? 2'b01 : 2'b10};
  endfunction

  function automatic logic [NE*EW-1:0] rvec();
    logic [NE*EW-1:0] v;
    for (int i = 0; i < NE; i++) begin
      int s = $urandom % 6;
      case (s)
        0: v[i*EW +: EW] = 16'h0000;
        1: v[i*EW +: EW] = 16'h8000;
        2: v[i*EW +: EW] = 16'h7c01;
        3: v[i*EW +: EW] = 16'(($urandom % 3));
        default: v[i*EW +: EW] = 16'($urandom);
      endcase
    end
    return v;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [NE*EW-1:0] va, vb;
    repeat (3) @(negedge clk);
    // R1: outputs zero while reset
    chk("R1", "pred_we", 128'(pred_we), 0);
    chk("R1", "pred_bits", 128'(pred_bits), 0);
    chk("R1", "cmp_illegal", 128'(cmp_illegal), 0);
    chk("R1", "mrg_out", 128'(mrg_out), 0);
    rst = 1'b0;
    va = rvec(); vb = va;
    va[0 +: 16] = 16'h0005; vb[0 +: 16] = 16'hfffb;
    // R3 integer ops, full length
    step(1, mk_cmp(0, 0, 0, 3, 1), 4'd8, va, vb, 0, 0, 0, 0);
    step(1, mk_cmp(0, 1, 0, 7, 1), 4'd8, va, vb, 0, 0, 0, 0);
    step(1, mk_cmp(1, 0, 0, 0, 1), 4'd8, va, vb, 0, 0, 0, 0);
    step(1, mk_cmp(1, 1, 0, 5, 1), 4'd8, va, vb, 0, 0, 0, 0);
    // R6: vl zero, partial and above NELEM
    step(1, mk_cmp(0, 0, 0, 1, 1), 4'd0, va, vb, 0, 0, 0, 0);
    step(1, mk_cmp(0, 0, 0, 1, 1), 4'd3, va, vb, 0, 0, 0, 0);
    step(1, mk_cmp(0, 0, 0, 1, 1), 4'd15, va, vb, 0, 0, 0, 0);
    // R4: +0 vs -0 equal, NaN false
    va = '0; vb = {NE{16'h8000}};
    va[16 +: 16] = 16'h7c01; vb[16 +: 16] = 16'h7c01;
    va[32 +: 16] = 16'hbc00; vb[32 +: 16] = 16'h3c00;
    step(1, mk_cmp(0, 0, 1, 2, 1), 4'd8, va, vb, 0, 0, 0, 0);
    step(1, mk_cmp(0, 1, 1, 2, 1), 4'd8, va, vb, 0, 0, 0, 0);
    // R5: float NE / GE illegal
    step(1, mk_cmp(1, 0, 1, 4, 1), 4'd8, va, vb, 0, 0, 0, 0);
    step(1, mk_cmp(1, 1, 1, 4, 1), 4'd8, va, vb, 0, 0, 0, 0);
    // R7: wrong quadrant and wrong funct3
    step(1, mk_cmp(0, 0, 0, 6, 0), 4'd8, va, vb, 0, 0, 0, 0);
    step(1, 16'h8c05, 4'd8, va, vb, 0, 0, 0, 0);
    // R8: merge keeps old where mask 0 or beyond vl
    step(0, 0, 4'd5, 0, 0, 1, 8'hb5, {NE{16'h1111}}, {NE{16'h2222}});
    step(0, 0, 4'd15, 0, 0, 1, 8'h0f, {NE{16'h3333}}, {NE{16'h4444}});
    step(0, 0, 4'd15, 0, 0, 0, 8'hff, {NE{16'h5555}}, {NE{16'h6666}});
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] ins = mk_cmp(1'($urandom), 1'($urandom), 1'($urandom),
                                int'($urandom % 8), ($urandom % 8) != 0);
      va = rvec();
      vb = ($urandom % 3 == 0) ? va : rvec();
      step(1'($urandom), ins, 4'($urandom), va, vb,
           1'($urandom), 8'($urandom), rvec(), rvec());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule